// File: doc/BRIEF.md
# Translation Response Fan-out

After the translation hierarchy answers the leader of a coalesced group, this block turns that single answer into one response per group member. It takes the completed translation through a valid/ready handshake: returned physical address, page-size shift, uncacheable flag, entry valid flag, entry virtual and physical page, and hit level. It then walks the group's membership list one member per cycle. The membership list is held in an external outstanding table and read through a combinational index/data interface.

Each member's physical address is formed from the translated physical page plus the member's own page offset. The page mask comes from the page size that came back with the translation, so it is not a fixed size. The leader keeps the address it was given. Every response goes to the return port recorded for that member. In the cycle of the final response the block tells the outstanding table that the group's page entry may be freed, so a later group for the same page can issue without a race. A group with no recorded members is flagged as an error, and its entry is still released.

Top module: `xlat_fanout`

## Requirements
- R1: `cmp_ready` is high exactly when the block is idle. A translation is taken on a clock edge where `cmp_valid` and `cmp_ready` are both high, and all of its fields are captured then. Changes on the completion inputs after that edge have no effect on the group's responses.
- R2: A group of N ≥ 1 members (N read from `grp_count` for `cmp_grp` at the accepting edge) produces exactly N responses, with `rsp_valid` high in the N consecutive cycles that follow the accepting edge. `cmp_ready` is low in those N cycles, and the block is idle again in the cycle after the last one.
- R3: Members are answered in ascending member index, starting at index 0, which is the leader. `rsp_leader` is high only for index 0. `rsp_port` equals the `mbr_port` recorded for the member being answered.
- R4: With page shift s (page size 2^s, mask M = 2^s − 1), a non-leader response carries `(returned paddr & ~M) | (member vaddr[PA_W-1:0] & M)`. A shift of 0 gives an empty mask.
- R5: The leader response carries the returned physical address unchanged, including its low bits.
- R6: The uncacheable flag, entry valid flag, entry virtual page, entry physical page and hit level of the translation are copied into every response of the group.
- R7: `rsp_pop_level` is high for a member that is not a prefetch and low for a prefetch member.
- R8: `rel_valid` is high for exactly one cycle per accepted group, with `rel_grp` equal to the group id. For a non-empty group this is the cycle of the last response.
- R9: A group whose recorded member count is 0 produces no response. It gives one cycle with `err_empty` and `rel_valid` both high and `cmp_ready` low, then returns to idle.
- R10: After reset the block is idle: `cmp_ready` high, and `rsp_valid`, `rel_valid` and `err_empty` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Completed translation offered |
| cmp_ready | output | 1 | Block idle, translation accepted this cycle if offered |
| cmp_grp | input | GRP_W | Outstanding-table group id of the translation |
| cmp_paddr | input | PA_W | Physical address returned for the leader |
| cmp_pg_shift | input | SH_W | log2 of the page size of the returned entry |
| cmp_uncache | input | 1 | Translation is uncacheable |
| cmp_entry_valid | input | 1 | Valid bit of the returned entry |
| cmp_ent_vpage | input | VA_W | Virtual page of the returned entry |
| cmp_ent_ppage | input | PA_W | Physical page of the returned entry |
| cmp_hit_lvl | input | HIT_W | Hierarchy level where the translation hit |
| mbr_grp | output | GRP_W | Group being read from the membership store |
| mbr_idx | output | IDX_W | Member index being read |
| grp_count | input | CNT_W | Member count of group `mbr_grp` |
| mbr_vaddr | input | VA_W | Virtual address of member `mbr_idx` |
| mbr_port | input | PORT_W | Recorded return port of that member |
| mbr_prefetch | input | 1 | Member is a prefetch |
| rsp_valid | output | 1 | A member response is presented |
| rsp_port | output | PORT_W | Return port for the response |
| rsp_leader | output | 1 | Response belongs to the group leader |
| rsp_paddr | output | PA_W | Physical address of the member |
| rsp_uncache | output | 1 | Uncacheable flag for the member |
| rsp_entry_valid | output | 1 | Copied entry valid bit |
| rsp_ent_vpage | output | VA_W | Copied entry virtual page |
| rsp_ent_ppage | output | PA_W | Copied entry physical page |
| rsp_hit_lvl | output | HIT_W | Copied hit level |
| rsp_pop_level | output | 1 | Remove one request-count level for this member |
| rel_valid | output | 1 | Free the group's page entry |
| rel_grp | output | GRP_W | Group whose entry is freed |
| err_empty | output | 1 | Group had no recorded members |

## Verification
Several properties are checked on every cycle. The member index advances by one within a burst. An accepted non-empty group opens with a leader response. Responses never overlap `cmp_ready`. A release is never repeated in the following cycle, and an empty group raises its error and release together. Every non-leader address agrees with the member's offset under the page mask and with the translated page above it. The bench scenarios are needed for the rest: exact response counts and port routing per group, the leader's untouched low bits, copying of the entry fields, the prefetch-dependent pop, page shifts from 0 to 39, back-to-back groups, and a completion held high while the block is busy.

// File: rtl/xlat_fanout_pkg.sv
package xlat_fanout_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SEND  = 2'd1,
      ST_FAULT = 2'd2
   } fan_state_e;
endpackage

// File: rtl/xlat_fanout_seq.sv
module xlat_fanout_seq
   import xlat_fanout_pkg::*;
#(
   parameter int MAX_MBR = 8,
   localparam int CNT_W = $clog2(MAX_MBR + 1),
   localparam int IDX_W = $clog2(MAX_MBR)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic [CNT_W-1:0] start_cnt,
   output logic             idle,
   output logic             accept,
   output logic             sending,
   output logic             fault,
   output logic             last,
   output logic [IDX_W-1:0] idx
);
   fan_state_e       state;
   logic [CNT_W-1:0] cnt;

   assign idle    = (state == ST_IDLE);
   assign accept  = start_req && idle;
   assign sending = (state == ST_SEND);
   assign fault   = (state == ST_FAULT);
   assign last    = sending && ((CNT_W'(idx) + CNT_W'(1)) == cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  idx <= '0;
                  cnt <= start_cnt;
                  state <= (start_cnt == '0) ? ST_FAULT : ST_SEND;
               end
            end
            ST_SEND: begin
               if (last) begin
                  state <= ST_IDLE;
                  idx   <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   // R3: within a burst the member index steps by exactly one
   assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sending && !last) |=> (sending && idx == IDX_W'($past(idx) + 1'b1)));

   // R9: an empty group goes to the fault cycle
   assert_empty_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && start_cnt == '0) |=> fault);

   // R2: member count never exceeds the storage depth
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (start_cnt <= CNT_W'(MAX_MBR)));
endmodule

// File: rtl/xlat_fanout_mask.sv
module xlat_fanout_mask #(
   parameter int PA_W = 40,
   localparam int SH_W = $clog2(PA_W)
) (
   input  logic [SH_W-1:0] pg_shift,
   output logic [PA_W-1:0] mask
);
   // one comparator per address bit: bit b is inside the page offset when b < shift
   for (genvar b = 0; b < PA_W; b++) begin : g_bit
      assign mask[b] = (SH_W'(b) < pg_shift);
   end
endmodule

// File: rtl/xlat_fanout_addr.sv
module xlat_fanout_addr #(
   parameter int PA_W = 40
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic            leader,
   input  logic [PA_W-1:0] ret_paddr,
   input  logic [PA_W-1:0] mask,
   input  logic [PA_W-1:0] va_low,
   output logic [PA_W-1:0] paddr
);
   logic [PA_W-1:0] page_base;

   assign page_base = ret_paddr & ~mask;
   assign paddr     = leader ? ret_paddr : (page_base | (va_low & mask));

   // R4: a non-leader address keeps the member offset and the translated page
   assert_member_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !leader) |->
         (((paddr & mask) == (va_low & mask)) && ((paddr & ~mask) == (ret_paddr & ~mask))));
endmodule

// File: rtl/xlat_fanout.sv
module xlat_fanout #(
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int MAX_MBR = 8,
   parameter int GRP_W   = 4,
   parameter int NPORT   = 4,
   parameter int HIT_W   = 2,
   localparam int CNT_W  = $clog2(MAX_MBR + 1),
   localparam int IDX_W  = $clog2(MAX_MBR),
   localparam int PORT_W = $clog2(NPORT),
   localparam int SH_W   = $clog2(PA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_valid,
   output logic              cmp_ready,
   input  logic [GRP_W-1:0]  cmp_grp,
   input  logic [PA_W-1:0]   cmp_paddr,
   input  logic [SH_W-1:0]   cmp_pg_shift,
   input  logic              cmp_uncache,
   input  logic              cmp_entry_valid,
   input  logic [VA_W-1:0]   cmp_ent_vpage,
   input  logic [PA_W-1:0]   cmp_ent_ppage,
   input  logic [HIT_W-1:0]  cmp_hit_lvl,
   output logic [GRP_W-1:0]  mbr_grp,
   output logic [IDX_W-1:0]  mbr_idx,
   input  logic [CNT_W-1:0]  grp_count,
   input  logic [VA_W-1:0]   mbr_vaddr,
   input  logic [PORT_W-1:0] mbr_port,
   input  logic              mbr_prefetch,
   output logic              rsp_valid,
   output logic [PORT_W-1:0] rsp_port,
   output logic              rsp_leader,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_uncache,
   output logic              rsp_entry_valid,
   output logic [VA_W-1:0]   rsp_ent_vpage,
   output logic [PA_W-1:0]   rsp_ent_ppage,
   output logic [HIT_W-1:0]  rsp_hit_lvl,
   output logic              rsp_pop_level,
   output logic              rel_valid,
   output logic [GRP_W-1:0]  rel_grp,
   output logic              err_empty
);
   if (PA_W > VA_W) begin : g_bad_width
      $error("physical address wider than virtual address");
   end
   if (MAX_MBR < 2) begin : g_bad_depth
      $error("group depth must be at least 2");
   end
   if (NPORT < 2) begin : g_bad_ports
      $error("at least two return ports required");
   end

   logic              idle, accept, sending, fault, last;
   logic [IDX_W-1:0]  idx;
   logic [GRP_W-1:0]  cap_grp;
   logic [PA_W-1:0]   cap_paddr, cap_ppage;
   logic [SH_W-1:0]   cap_shift;
   logic              cap_uncache, cap_evalid;
   logic [VA_W-1:0]   cap_vpage;
   logic [HIT_W-1:0]  cap_hit;
   logic [PA_W-1:0]   pg_mask;

   xlat_fanout_seq #(.MAX_MBR(MAX_MBR)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_req(cmp_valid), .start_cnt(grp_count),
      .idle(idle), .accept(accept), .sending(sending), .fault(fault),
      .last(last), .idx(idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_grp     <= '0;
         cap_paddr   <= '0;
         cap_ppage   <= '0;
         cap_shift   <= '0;
         cap_uncache <= 1'b0;
         cap_evalid  <= 1'b0;
         cap_vpage   <= '0;
         cap_hit     <= '0;
      end else if (accept) begin
         cap_grp     <= cmp_grp;
         cap_paddr   <= cmp_paddr;
         cap_ppage   <= cmp_ent_ppage;
         cap_shift   <= cmp_pg_shift;
         cap_uncache <= cmp_uncache;
         cap_evalid  <= cmp_entry_valid;
         cap_vpage   <= cmp_ent_vpage;
         cap_hit     <= cmp_hit_lvl;
      end
   end

   xlat_fanout_mask #(.PA_W(PA_W)) u_mask (
      .pg_shift(cap_shift), .mask(pg_mask)
   );

   xlat_fanout_addr #(.PA_W(PA_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .valid(sending), .leader(rsp_leader),
      .ret_paddr(cap_paddr), .mask(pg_mask), .va_low(mbr_vaddr[PA_W-1:0]),
      .paddr(rsp_paddr)
   );

   // membership read: the incoming group while idle, the captured one while busy
   assign mbr_grp   = idle ? cmp_grp : cap_grp;
   assign mbr_idx   = idx;
   assign cmp_ready = idle;

   assign rsp_valid       = sending;
   assign rsp_leader      = sending && (idx == '0);
   assign rsp_port        = mbr_port;
   assign rsp_uncache     = cap_uncache;
   assign rsp_entry_valid = cap_evalid;
   assign rsp_ent_vpage   = cap_vpage;
   assign rsp_ent_ppage   = cap_ppage;
   assign rsp_hit_lvl     = cap_hit;
   assign rsp_pop_level   = sending && !mbr_prefetch;

   assign rel_valid = last || fault;
   assign rel_grp   = cap_grp;
   assign err_empty = fault;

   // R8: a release is a single-cycle pulse
   assert_release_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |=> !rel_valid);

   // R9: the empty-group error releases the entry and sends nothing
   assert_empty_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_empty |-> (rel_valid && !rsp_valid));

   // R3: a non-empty group starts with the leader right after acceptance
   assert_leader_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && cmp_ready && grp_count != '0) |=> (rsp_valid && rsp_leader));

   // R2: no new translation is taken while responses are going out
   assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !cmp_ready);
endmodule

// File: tb/tb_xlat_fanout.sv
`timescale 1ns/1ps
module tb_xlat_fanout;
   localparam int VA_W = 48, PA_W = 40, MAX_MBR = 8, GRP_W = 4, NPORT = 4, HIT_W = 2;
   localparam int CNT_W = 4, IDX_W = 3, PORT_W = 2, SH_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              cmp_valid, cmp_ready, cmp_uncache, cmp_entry_valid;
   logic [GRP_W-1:0]  cmp_grp, mbr_grp, rel_grp;
   logic [PA_W-1:0]   cmp_paddr, cmp_ent_ppage, rsp_paddr, rsp_ent_ppage;
   logic [SH_W-1:0]   cmp_pg_shift;
   logic [VA_W-1:0]   cmp_ent_vpage, mbr_vaddr, rsp_ent_vpage;
   logic [HIT_W-1:0]  cmp_hit_lvl, rsp_hit_lvl;
   logic [IDX_W-1:0]  mbr_idx;
   logic [CNT_W-1:0]  grp_count;
   logic [PORT_W-1:0] mbr_port, rsp_port;
   logic              mbr_prefetch, rsp_valid, rsp_leader, rsp_uncache, rsp_entry_valid;
   logic              rsp_pop_level, rel_valid, err_empty;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   function automatic logic [VA_W-1:0] vfun(input int g, input int i);
      return 48'h5D3C_9A0F_0000 ^ (48'(g) << 28) ^ (48'(i) * 48'h0013_5F2B_7C91);
   endfunction
   function automatic logic [PORT_W-1:0] pfun(input int g, input int i);
      return PORT_W'(g + 3 * i);
   endfunction
   function automatic logic prefun(input int g, input int i);
      return ((g + i) % 3) == 0;
   endfunction

   logic [CNT_W-1:0] gcnt [16];
   assign grp_count    = gcnt[mbr_grp];
   assign mbr_vaddr    = vfun(int'(mbr_grp), int'(mbr_idx));
   assign mbr_port     = pfun(int'(mbr_grp), int'(mbr_idx));
   assign mbr_prefetch = prefun(int'(mbr_grp), int'(mbr_idx));

   xlat_fanout #(.VA_W(VA_W), .PA_W(PA_W), .MAX_MBR(MAX_MBR), .GRP_W(GRP_W),
                 .NPORT(NPORT), .HIT_W(HIT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
      .cmp_grp(cmp_grp), .cmp_paddr(cmp_paddr), .cmp_pg_shift(cmp_pg_shift),
      .cmp_uncache(cmp_uncache), .cmp_entry_valid(cmp_entry_valid),
      .cmp_ent_vpage(cmp_ent_vpage), .cmp_ent_ppage(cmp_ent_ppage),
      .cmp_hit_lvl(cmp_hit_lvl), .mbr_grp(mbr_grp), .mbr_idx(mbr_idx),
      .grp_count(grp_count), .mbr_vaddr(mbr_vaddr), .mbr_port(mbr_port),
      .mbr_prefetch(mbr_prefetch), .rsp_valid(rsp_valid), .rsp_port(rsp_port),
      .rsp_leader(rsp_leader), .rsp_paddr(rsp_paddr), .rsp_uncache(rsp_uncache),
      .rsp_entry_valid(rsp_entry_valid), .rsp_ent_vpage(rsp_ent_vpage),
      .rsp_ent_ppage(rsp_ent_ppage), .rsp_hit_lvl(rsp_hit_lvl),
      .rsp_pop_level(rsp_pop_level), .rel_valid(rel_valid), .rel_grp(rel_grp),
      .err_empty(err_empty)
   );

   typedef struct packed {
      logic [3:0]  g;
      logic [5:0]  sh;
      logic [39:0] pa;
      logic        unc;
      logic [1:0]  hit;
   } vec_t;

   localparam vec_t VECS [7] = '{
      '{4'd1, 6'd12, 40'h12_3456_7ABC, 1'b0, 2'd1},
      '{4'd2, 6'd12, 40'hAB_CDEF_1234, 1'b1, 2'd2},
      '{4'd3, 6'd16, 40'h0F_0F0F_5555, 1'b0, 2'd0},
      '{4'd4, 6'd21, 40'h7E_DC5B_A987, 1'b1, 2'd3},
      '{4'd5, 6'd30, 40'h3C_A5A5_A5A5, 1'b0, 2'd2},
      '{4'd6, 6'd0,  40'h01_2345_6789, 1'b1, 2'd1},
      '{4'd7, 6'd39, 40'hFF_FFFF_FFFF, 1'b0, 2'd0}
   };

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // starts just after a negedge, ends at a negedge with the block idle
   task automatic run_group(input int g, input logic [5:0] sh, input logic [39:0] pa,
                            input logic unc, input logic [1:0] hit, input bit hold);
      logic [39:0] m, exp_pa;
      logic [47:0] vp, va;
      logic        ev;
      int          n;
      m  = (40'd1 << sh) - 40'd1;
      vp = 48'(g) * 48'h0111_0000_1000;
      ev = (g % 2) == 1;
      n  = int'(gcnt[g]);
      cmp_valid = 1'b1; cmp_grp = 4'(g); cmp_paddr = pa; cmp_pg_shift = sh;
      cmp_uncache = unc; cmp_entry_valid = ev; cmp_ent_vpage = vp;
      cmp_ent_ppage = pa & ~m; cmp_hit_lvl = hit;
      chk("R1 ready while idle", 64'(cmp_ready), 64'd1);
      @(posedge clk);
      @(negedge clk);
      // R1: scramble the completion inputs after acceptance
      cmp_valid = hold; cmp_grp = 4'(g + 1); cmp_paddr = ~pa; cmp_pg_shift = sh ^ 6'h15;
      cmp_uncache = ~unc; cmp_entry_valid = ~ev; cmp_ent_vpage = ~vp;
      cmp_ent_ppage = ~pa; cmp_hit_lvl = ~hit;
      if (n == 0) begin
         chk("R9 err_empty", 64'(err_empty), 64'd1);
         chk("R9 release", 64'({rel_valid, rel_grp}), 64'({1'b1, 4'(g)}));
         chk("R9 no response, not ready", 64'({rsp_valid, cmp_ready}), 64'd0);
         @(negedge clk);
      end else begin
         for (int i = 0; i < n; i++) begin
            va = vfun(g, i);
            exp_pa = (i == 0) ? pa : ((pa & ~m) | (va[39:0] & m));
            chk("R2 rsp_valid, ready low", 64'({rsp_valid, cmp_ready}), 64'b10);
            chk("R3 leader flag", 64'(rsp_leader), 64'(i == 0));
            chk("R3 return port", 64'(rsp_port), 64'(pfun(g, i)));
            chk((i == 0) ? "R5 leader paddr" : "R4 member paddr", 64'(rsp_paddr), 64'(exp_pa));
            chk("R6 copied fields",
                64'({rsp_uncache, rsp_entry_valid, rsp_hit_lvl}), 64'({unc, ev, hit}));
            chk("R6 copied pages", 64'(rsp_ent_vpage ^ {8'h0, rsp_ent_ppage}),
                64'(vp ^ {8'h0, pa & ~m}));
            chk("R7 pop level", 64'(rsp_pop_level), 64'(!prefun(g, i)));
            chk("R8 release timing", 64'({rel_valid, rel_grp}),
                (i == n - 1) ? 64'({1'b1, 4'(g)}) : 64'({1'b0, rel_grp}));
            chk("R9 no error", 64'(err_empty), 64'd0);
            @(negedge clk);
         end
      end
      cmp_valid = 1'b0;
      chk("R2 idle after group", 64'({cmp_ready, rsp_valid, rel_valid}), 64'b100);
   endtask

   initial begin
      for (int g = 0; g < 16; g++) gcnt[g] = '0;
      gcnt[1] = 4'd1; gcnt[2] = 4'd3; gcnt[3] = 4'd8; gcnt[4] = 4'd5;
      gcnt[5] = 4'd2; gcnt[6] = 4'd4; gcnt[7] = 4'd7; gcnt[9] = 4'd0;
      cmp_valid = 1'b0; cmp_grp = '0; cmp_paddr = '0; cmp_pg_shift = '0;
      cmp_uncache = 1'b0; cmp_entry_valid = 1'b0; cmp_ent_vpage = '0;
      cmp_ent_ppage = '0; cmp_hit_lvl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 reset ready", 64'(cmp_ready), 64'd1);
      chk("R10 reset outputs quiet", 64'({rsp_valid, rel_valid, err_empty}), 64'd0);
      // table walk, groups issued back to back
      for (int v = 0; v < 7; v++)
         run_group(int'(VECS[v].g), VECS[v].sh, VECS[v].pa, VECS[v].unc, VECS[v].hit, 1'b0);
      // R9: empty group
      run_group(9, 6'd12, 40'h55_0000_0ABC, 1'b1, 2'd3, 1'b0);
      // R1/R2: completion held high while busy is not taken
      run_group(3, 6'd14, 40'h44_3322_1100, 1'b1, 2'd2, 1'b1);
      // R2: quiet gap, then back-to-back pair
      @(negedge clk);
      chk("R2 stays idle", 64'({cmp_ready, rsp_valid}), 64'b10);
      run_group(2, 6'd13, 40'h9A_8765_4FED, 1'b0, 2'd1, 1'b0);
      run_group(1, 6'd20, 40'h00_00FF_F00F, 1'b1, 2'd3, 1'b0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog R2: actual %0d cycles expected completion", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule